// File: doc/BRIEF.md
# Reset Sequencer with Source Status

This block sequences system reset for a small microcontroller. It watches a shared, active-low board reset line. The line is modelled as a raw input plus an open-drain pull-down enable. It also takes reset requests from on-chip detectors: low supply voltage, watchdog expiry, an illegal opcode and an illegal address. Power-on enters through the block's asynchronous reset input. When any on-chip cause fires, the block pulls the board line low for a fixed span so that external chips reset too. It then releases the line and keeps its internal reset output high for a further span after the line is seen high again. Power-on and low-voltage causes add a long stabilisation stretch to the pull-down span.

A six-bit cause register records why the most recent reset happened, one bit per cause. An external assertion of the line halts the chip, because it holds the internal reset high. It is only recorded as the cause if the line stays low long enough. The required length is longer when the last recorded cause was power-on or low voltage. Software reads the cause register through a plain combinational read port.

Top module: `reset_sequencer`

## Requirements
- R1: While `por_ni` is low, `pin_oe_o` and `rst_o` are 1 and the cause register reads 0x01 (power-on only).
- R2: A watchdog, illegal-opcode or illegal-address request sampled at a clock edge makes `pin_oe_o` high for exactly LOW_CYCLES cycles, starting right after that edge.
- R3: A low-voltage request, or the release of `por_ni`, makes `pin_oe_o` high for exactly STRETCH_CYCLES + LOW_CYCLES cycles.
- R4: The line input passes through a two-flop synchroniser. `rst_o` stays high while a sequence runs and falls POST_CYCLES + 2 cycles after the pull-down ends, provided the line is then high. An internal request therefore keeps `rst_o` high for N + POST_CYCLES + 2 cycles, where N is its pull-down span.
- R5: An external low on the line sets `rst_o` from the second edge that samples it low. `rst_o` falls after the (L + POST_CYCLES + 2)-th edge, where L is the number of edges at which the line was sampled low.
- R6: When the last cause is not power-on or low voltage, an external low sampled at LOW_CYCLES + POST_CYCLES + 3 or more consecutive edges sets the cause register to 0x04. Any shorter low leaves the register unchanged.
- R7: When the last cause is power-on or low voltage, the threshold of R6 becomes STRETCH_CYCLES + LOW_CYCLES + POST_CYCLES + 3 edges.
- R8: The cause register is one-hot. Bit 0 is power-on, bit 1 low voltage, bit 2 external line, bit 3 watchdog, bit 4 illegal opcode and bit 5 illegal address. Each new cause clears all other bits.
- R9: When requests arrive together, the priority is low voltage, then watchdog, then illegal opcode, then illegal address.
- R10: A request that arrives during a running sequence restarts the pull-down phase with the span of the new cause.
- R11: `rd_data_o` is {2'b00, cause} when `rd_en_i` is 1 and 0 otherwise. Reading never changes the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reset-sequencer clock |
| por_ni | input | 1 | Asynchronous power-on reset, active low |
| pin_n_i | input | 1 | Raw level of the shared board reset line |
| pin_oe_o | output | 1 | Enable for the open-drain pull-down of the line |
| lvi_req_i | input | 1 | Low-voltage reset request |
| cop_req_i | input | 1 | Watchdog timeout reset request |
| ilop_req_i | input | 1 | Illegal-opcode reset request |
| ilad_req_i | input | 1 | Illegal-address reset request |
| rst_o | output | 1 | Internal reset to the rest of the chip |
| rd_en_i | input | 1 | Read enable for the cause register |
| rd_data_o | output | 8 | Cause register read data |

## Verification
The bench sweeps the external low length across the short threshold and across the long threshold. A design with the synchroniser latency miscounted, or with the wrong threshold after a power-on or low-voltage cause, would record the line one cycle early or late, or would use the short threshold where the long one applies. Every source is fired alone and in combinations to expose a wrong priority or a cause bit that fails to clear. Requests are also injected during the pull-down and release phases, so a sequencer that ignores them, or keeps the old span, shows a wrong pull-down length.

// File: rtl/reset_sequencer.sv
module reset_sequencer #(
  parameter int LOW_CYCLES     = 32,
  parameter int POST_CYCLES    = 32,
  parameter int STRETCH_CYCLES = 4096
) (
  input  logic       clk_i,
  input  logic       por_ni,
  input  logic       pin_n_i,
  output logic       pin_oe_o,
  input  logic       lvi_req_i,
  input  logic       cop_req_i,
  input  logic       ilop_req_i,
  input  logic       ilad_req_i,
  output logic       rst_o,
  input  logic       rd_en_i,
  output logic [7:0] rd_data_o
);
  localparam int SHORT_THR = LOW_CYCLES + POST_CYCLES + 3;
  localparam int LONG_THR  = STRETCH_CYCLES + SHORT_THR;
  localparam int CW        = $clog2(LONG_THR + 1) + 1;
  localparam int B_POR = 0, B_LVI = 1, B_PIN = 2, B_COP = 3, B_ILOP = 4, B_ILAD = 5;

  typedef enum logic [1:0] {S_IDLE, S_DRIVE, S_HOLD} st_t;

  st_t           state_q;
  logic [CW-1:0] cnt_q, lowcnt_q;
  logic [1:0]    sync_q;
  logic [5:0]    cause_q, cause_new;
  logic          pin_s, req_any, long_mode, pin_hit;

  assign pin_s     = sync_q[1];
  assign req_any   = lvi_req_i | cop_req_i | ilop_req_i | ilad_req_i;
  assign long_mode = cause_q[B_POR] | cause_q[B_LVI];
  assign pin_hit   = !pin_s && (lowcnt_q == CW'((long_mode ? LONG_THR : SHORT_THR) - 1));
  assign pin_oe_o  = (state_q == S_DRIVE);
  assign rst_o     = (state_q != S_IDLE) || !pin_s;
  assign rd_data_o = rd_en_i ? {2'b00, cause_q} : 8'h00;

  always_comb begin
    cause_new = '0;
    if (lvi_req_i)       cause_new[B_LVI]  = 1'b1;
    else if (cop_req_i)  cause_new[B_COP]  = 1'b1;
    else if (ilop_req_i) cause_new[B_ILOP] = 1'b1;
    else                 cause_new[B_ILAD] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge por_ni)
    if (!por_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], pin_n_i};

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      state_q <= S_DRIVE;
      cnt_q   <= CW'(STRETCH_CYCLES + LOW_CYCLES);
    end else if (req_any) begin
      state_q <= S_DRIVE;
      cnt_q   <= lvi_req_i ? CW'(STRETCH_CYCLES + LOW_CYCLES) : CW'(LOW_CYCLES);
    end else begin
      case (state_q)
        S_DRIVE:
          if (cnt_q == CW'(1)) begin
            state_q <= S_HOLD;
            cnt_q   <= CW'(POST_CYCLES);
          end else cnt_q <= cnt_q - CW'(1);
        S_HOLD:
          if (!pin_s)                cnt_q   <= CW'(POST_CYCLES);
          else if (cnt_q == CW'(1))  state_q <= S_IDLE;
          else                       cnt_q   <= cnt_q - CW'(1);
        default:
          if (!pin_s) begin
            state_q <= S_HOLD;
            cnt_q   <= CW'(POST_CYCLES);
          end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)                          lowcnt_q <= '0;
    else if (pin_s)                       lowcnt_q <= '0;
    else if (lowcnt_q != CW'(LONG_THR))   lowcnt_q <= lowcnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)       cause_q <= 6'b000001;
    else if (req_any)  cause_q <= cause_new;
    else if (pin_hit)  cause_q <= 6'b000100;
  end

  assert_req_pulls_line_R2: assert property (@(posedge clk_i) disable iff (!por_ni)
    req_any |=> pin_oe_o);
  assert_cause_onehot_R8: assert property (@(posedge clk_i) disable iff (!por_ni)
    $countones(cause_q) == 1);
  assert_cause_stable_R11: assert property (@(posedge clk_i) disable iff (!por_ni)
    (!req_any && pin_s) |=> $stable(cause_q));
  assert_release_needs_high_line_R4: assert property (@(posedge clk_i) disable iff (!por_ni)
    $fell(rst_o) |-> (pin_s && $past(pin_s)));
  assert_pin_flag_needs_low_R6: assert property (@(posedge clk_i) disable iff (!por_ni)
    $rose(cause_q[B_PIN]) |-> !$past(pin_s));
  assert_rst_rise_has_cause_R5: assert property (@(posedge clk_i) disable iff (!por_ni)
    $rose(rst_o) |-> ($past(req_any) || !pin_s));
endmodule

// File: tb/test_reset_sequencer.sv
module test_reset_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int LOW = 4, POST = 4, STR = 16;
  localparam int TS = LOW + POST + 3;
  localparam int TL = STR + TS;
  localparam int C_POR = 1, C_LVI = 2, C_PIN = 4, C_COP = 8, C_ILOP = 16, C_ILAD = 32;

  logic clk = 0, por_n = 0, ext_n = 1, rd_en = 1;
  logic lvi = 0, cop = 0, ilop = 0, ilad = 0;
  logic pin_oe, rst, pin_n;
  logic [7:0] rd_data;
  int checks = 0, errors = 0;
  bit done = 0;

  assign pin_n = pin_oe ? 1'b0 : ext_n;
  always #(CLK_PERIOD/2) clk = ~clk;

  reset_sequencer #(.LOW_CYCLES(LOW), .POST_CYCLES(POST), .STRETCH_CYCLES(STR)) i_reset_sequencer (
    .clk_i(clk), .por_ni(por_n), .pin_n_i(pin_n), .pin_oe_o(pin_oe),
    .lvi_req_i(lvi), .cop_req_i(cop), .ilop_req_i(ilop), .ilad_req_i(ilad),
    .rst_o(rst), .rd_en_i(rd_en), .rd_data_o(rd_data));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(output int oe_n, output int rst_n);
    oe_n = 0; rst_n = 0;
    while (rst && rst_n < 1000) begin
      if (pin_oe) oe_n++;
      rst_n++;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic fire(string req, logic l, logic c, logic o, logic a, int span, int cause);
    int oe_n, rst_n;
    lvi = l; cop = c; ilop = o; ilad = a;
    @(negedge clk);
    lvi = 0; cop = 0; ilop = 0; ilad = 0;
    measure(oe_n, rst_n);
    check({req, " pull-down span"}, oe_n, span);
    check({req, " R4 internal reset span"}, rst_n, span + POST + 2);
    check({req, " R8 cause"}, rd_data, cause);
  endtask

  task automatic press(string req, int len, int exp_cause);
    ext_n = 0;
    repeat (len) @(negedge clk);
    ext_n = 1;
    if (len >= 2) check({req, " R5 rst during press"}, rst, 1);
    repeat (POST + 1) @(negedge clk);
    check({req, " R5 rst before release"}, rst, 1);
    @(negedge clk);
    check({req, " R5 rst after release"}, rst, 0);
    check({req, " cause after press"}, rd_data, exp_cause);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int oe_n, rst_n;
    repeat (3) @(negedge clk);
    check("R1 oe in reset", pin_oe, 1);
    check("R1 rst in reset", rst, 1);
    check("R1 cause in reset", rd_data, C_POR);
    por_n = 1;
    measure(oe_n, rst_n);
    check("R3 power-on span", oe_n, STR + LOW);
    check("R4 power-on reset span", rst_n, STR + LOW + POST + 2);
    check("R8 power-on cause", rd_data, C_POR);

    rd_en = 0; #1;
    check("R11 disabled read", rd_data, 0);
    for (int i = 0; i < 4; i++) begin rd_en = ~rd_en; @(negedge clk); end
    rd_en = 1; #1;
    check("R11 read no side effect", rd_data, C_POR);

    fire("R3 lvi", 1, 0, 0, 0, STR + LOW, C_LVI);
    fire("R2 cop", 0, 1, 0, 0, LOW, C_COP);
    fire("R2 ilop", 0, 0, 1, 0, LOW, C_ILOP);
    fire("R2 ilad", 0, 0, 0, 1, LOW, C_ILAD);
    fire("R9 all", 1, 1, 1, 1, STR + LOW, C_LVI);
    fire("R9 cop first", 0, 1, 1, 1, LOW, C_COP);
    fire("R9 ilop first", 0, 0, 1, 1, LOW, C_ILOP);

    cop = 1; @(negedge clk); cop = 0;
    @(negedge clk);
    fire("R10 restart in pull-down", 0, 0, 1, 0, LOW, C_ILOP);
    cop = 1; @(negedge clk); cop = 0;
    repeat (LOW + 1) @(negedge clk);
    check("R10 in release phase", pin_oe, 0);
    fire("R10 restart in release", 1, 0, 0, 0, STR + LOW, C_LVI);

    for (int len = 1; len <= TS + 2; len++) begin
      fire("R2 setup cop", 0, 1, 0, 0, LOW, C_COP);
      press("R6 short threshold", len, (len >= TS) ? C_PIN : C_COP);
    end
    for (int len = TS; len <= TL + 1; len++) begin
      fire("R3 setup lvi", 1, 0, 0, 0, STR + LOW, C_LVI);
      press("R7 long threshold", len, (len >= TL) ? C_PIN : C_LVI);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule